// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block supervises software with a 12-bit down-counter that steps once per pulse of a slow tick enable. The tick is nominally 256 Hz, so a full count of 0xFFF spans about sixteen seconds. Software keeps the system alive by writing a keyed restart command, which reloads the counter. If the counter is allowed to run out, the block raises a fault.

The restart is also policed from below. A restart is accepted only once the counter has fallen to or under a programmable window delta. A restart that arrives while the counter is still above the delta counts as a fault, just as an underflow does.

A configuration register holds the reload value, the window delta and the behaviour flags. It accepts exactly one write after reset, so a boot stage can lock the policy. A fault can raise an interrupt, a one-cycle reset request, or both. The reset request can be tagged as processor-only. Sticky status bits record which kind of fault occurred. All registers are reached through a simple word-addressed read/write port with one cycle of read latency.

Top module: `wdog_window_top`

## Requirements
- R1: After reset, the configuration register (address 1) reads 0x3FFF2FFF, the status register (address 2) reads 0, the count register (address 3) reads 0xFFF, and rst_req, rst_proc and irq are low. Reads return data one clock after rd_en.
- R2: The configuration register takes only its first write after reset, and that write loads the counter with its reload field. The fields are: reload in bits [11:0], delta in bits [27:16], fault-interrupt enable in bit 12, reset enable in bit 13, processor-only in bit 14, disable in bit 15, idle-halt in bit 28 and debug-halt in bit 29. Every later write leaves both the register and the counter unchanged.
- R3: Each tick lowers the counter by one. A tick that arrives while the counter is 0 is an underflow fault. The counter then reloads and keeps running, so the fault comes on the (reload+1)-th tick after a load.
- R4: A write to the control register (address 0) with 0xA5 in bits [31:24] and bit 0 set reloads the counter when the count is at or below the delta. A write with any other key, or with bit 0 clear, leaves the counter unchanged.
- R5: A keyed restart while the count is above the delta is an early-restart fault, and the counter still reloads.
- R6: While the disable bit is set, the counter holds its value, restarts have no effect and no fault occurs.
- R7: A fault with reset enable set gives a one-cycle rst_req. rst_proc pulses with it only when processor-only is set. With reset enable clear, no rst_req is produced.
- R8: irq is high while the status register is nonzero and fault-interrupt enable is set. It stays low when fault-interrupt enable is clear.
- R9: Status bit 0 records an underflow and bit 1 records an early restart. A read returns the bits and clears them.
- R10: The counter freezes on ticks while idle_in is high with idle-halt set, or while dbg_in is high with debug-halt set. It runs when the matching halt bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Slow count enable, one cycle per step |
| idle_in | input | 1 | System idle indication |
| dbg_in | input | 1 | Debugger halt indication |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid one clock after rd_en |
| rst_req | output | 1 | Reset request pulse |
| rst_proc | output | 1 | Reset request limited to the processor |
| irq | output | 1 | Fault interrupt |

## Verification
The bench builds the block with its default parameters: a 12-bit counter, key 0xA5 and a two-bit address. It drives the tick input itself instead of waiting on a 256 Hz rate. Small reload values written through the one-shot configuration write bring underflow, the window boundary where count equals delta, and back-to-back restarts within a handful of ticks. The full-width reset value of 0xFFF is still used for the reset and halt checks.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // word addresses of the register port
  localparam int REG_CTRL = 0;
  localparam int REG_MODE = 1;
  localparam int REG_STAT = 2;
  localparam int REG_CNT  = 3;

  // configuration bit positions
  localparam int DELTA_LSB = 16;
  localparam int B_IRQ_EN  = 12;
  localparam int B_RST_EN  = 13;
  localparam int B_CPU     = 14;
  localparam int B_OFF     = 15;
  localparam int B_IDLE    = 28;
  localparam int B_DBG     = 29;
  localparam logic [31:0] FLAG_MASK = 32'h3000_F000;

  typedef struct packed {
    logic halt_dbg;
    logic halt_idle;
    logic off;
    logic cpu_only;
    logic rst_en;
    logic irq_en;
  } mode_flags_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int          CNT_W    = 12,
  parameter int          ADDR_W   = 2,
  parameter logic [7:0]  KEY      = 8'hA5,
  parameter logic [31:0] MODE_RST = 32'h3FFF_2FFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic [CNT_W-1:0]  count,
  input  logic [1:0]        status,
  output logic [31:0]       rdata,
  output logic [CNT_W-1:0]  reload,
  output logic [CNT_W-1:0]  delta,
  output logic [CNT_W-1:0]  load_val,
  output mode_flags_t       flags,
  output logic              mode_ld,
  output logic              restart_req,
  output logic              status_rd
);
  localparam logic [31:0] FIELD     = (32'd1 << CNT_W) - 32'd1;
  localparam logic [31:0] MODE_MASK = FIELD | (FIELD << DELTA_LSB) | FLAG_MASK;

  logic [31:0] mode_q;
  logic        locked_q;
  logic        sel_ctrl, sel_mode, sel_stat, sel_cnt;

  assign sel_ctrl = (addr == ADDR_W'(REG_CTRL));
  assign sel_mode = (addr == ADDR_W'(REG_MODE));
  assign sel_stat = (addr == ADDR_W'(REG_STAT));
  assign sel_cnt  = (addr == ADDR_W'(REG_CNT));

  // one-shot configuration write
  assign mode_ld     = wr_en && sel_mode && !locked_q;
  assign load_val    = wdata[CNT_W-1:0];
  assign restart_req = wr_en && sel_ctrl && (wdata[31:24] == KEY) && wdata[0];
  assign status_rd   = rd_en && sel_stat;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= MODE_RST & MODE_MASK;
      locked_q <= 1'b0;
    end else if (mode_ld) begin
      mode_q   <= wdata & MODE_MASK;
      locked_q <= 1'b1;
    end
  end

  assign reload          = mode_q[CNT_W-1:0];
  assign delta           = mode_q[DELTA_LSB +: CNT_W];
  assign flags.irq_en    = mode_q[B_IRQ_EN];
  assign flags.rst_en    = mode_q[B_RST_EN];
  assign flags.cpu_only  = mode_q[B_CPU];
  assign flags.off       = mode_q[B_OFF];
  assign flags.halt_idle = mode_q[B_IDLE];
  assign flags.halt_dbg  = mode_q[B_DBG];

  // registered read path
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      if (sel_mode)      rdata <= mode_q;
      else if (sel_stat) rdata <= {30'd0, status};
      else if (sel_cnt)  rdata <= 32'(count);
      else               rdata <= '0;
    end
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int          CNT_W   = 12,
  parameter logic [CNT_W-1:0] CNT_RST = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             run,
  input  logic             restart,
  input  logic             mode_ld,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload,
  input  logic [CNT_W-1:0] delta,
  output logic [CNT_W-1:0] count,
  output logic             uf_p,
  output logic             early_p
);
  // priority: configuration load, then restart, then tick
  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= CNT_RST;
      uf_p    <= 1'b0;
      early_p <= 1'b0;
    end else begin
      uf_p    <= 1'b0;
      early_p <= 1'b0;
      if (mode_ld) begin
        count <= load_val;
      end else if (restart) begin
        count   <= reload;
        early_p <= (count > delta);
      end else if (tick && run) begin
        if (count == '0) begin
          count <= reload;
          uf_p  <= 1'b1;
        end else begin
          count <= count - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/wdog_fault.sv
module wdog_fault
  import wdog_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        uf_p,
  input  logic        early_p,
  input  mode_flags_t flags,
  input  logic        status_rd,
  output logic [1:0]  status,
  output logic        rst_req,
  output logic        rst_proc,
  output logic        irq
);
  logic fault;
  assign fault = uf_p || early_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      status   <= '0;
      rst_req  <= 1'b0;
      rst_proc <= 1'b0;
      irq      <= 1'b0;
    end else begin
      // a new fault wins over a clearing read in the same cycle
      status   <= (status & ~{2{status_rd}}) | {early_p, uf_p};
      rst_req  <= fault && flags.rst_en;
      rst_proc <= fault && flags.rst_en && flags.cpu_only;
      irq      <= flags.irq_en && (status != 2'b00);
    end
  end
endmodule

// File: rtl/wdog_window_top.sv
module wdog_window_top
  import wdog_pkg::*;
#(
  parameter int          CNT_W    = 12,
  parameter int          ADDR_W   = 2,
  parameter logic [7:0]  KEY      = 8'hA5,
  parameter logic [31:0] MODE_RST = 32'h3FFF_2FFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              idle_in,
  input  logic              dbg_in,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              rst_req,
  output logic              rst_proc,
  output logic              irq
);
  localparam logic [CNT_W-1:0] CNT_RST = MODE_RST[CNT_W-1:0];

  logic [CNT_W-1:0] cnt, reload, delta, load_val;
  mode_flags_t      flags;
  logic             mode_ld, restart_req, status_rd;
  logic             uf_p, early_p, halt, run, restart;
  logic [1:0]       status;

  assign halt    = (flags.halt_idle && idle_in) || (flags.halt_dbg && dbg_in);
  assign run     = !flags.off && !halt;
  assign restart = restart_req && !flags.off;

  wdog_regs #(
    .CNT_W(CNT_W), .ADDR_W(ADDR_W), .KEY(KEY), .MODE_RST(MODE_RST)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .count(cnt), .status(status), .rdata(rdata),
    .reload(reload), .delta(delta), .load_val(load_val), .flags(flags),
    .mode_ld(mode_ld), .restart_req(restart_req), .status_rd(status_rd)
  );

  wdog_counter #(.CNT_W(CNT_W), .CNT_RST(CNT_RST)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .run(run), .restart(restart),
    .mode_ld(mode_ld), .load_val(load_val), .reload(reload), .delta(delta),
    .count(cnt), .uf_p(uf_p), .early_p(early_p)
  );

  wdog_fault u_fault (
    .clk(clk), .rst(rst), .uf_p(uf_p), .early_p(early_p), .flags(flags),
    .status_rd(status_rd), .status(status), .rst_req(rst_req),
    .rst_proc(rst_proc), .irq(irq)
  );
endmodule

// File: rtl/wdog_window_chk.sv
module wdog_window_chk
  import wdog_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             idle_in,
  input logic             dbg_in,
  input logic             wr_en,
  input logic             rst_req,
  input logic             rst_proc,
  input logic             irq,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] reload,
  input mode_flags_t      flags,
  input logic [1:0]       status,
  input logic             uf_p,
  input logic             early_p
);
  logic frozen;
  assign frozen = (idle_in && flags.halt_idle) || (dbg_in && flags.halt_dbg);

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
    count <= reload);

  assert_tick_step_R3: assert property (@(posedge clk) disable iff (rst)
    (tick && !wr_en && !flags.off && !frozen && count != '0)
    |=> count == CNT_W'($past(count) - 1'b1));

  assert_off_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    flags.off |=> ($stable(count) && !uf_p && !early_p));

  assert_req_cause_R7: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> $past(uf_p || early_p));

  assert_req_follows_R7: assert property (@(posedge clk) disable iff (rst)
    ((uf_p || early_p) && flags.rst_en) |=> rst_req);

  assert_proc_in_req_R7: assert property (@(posedge clk) disable iff (rst)
    rst_proc |-> rst_req);

  assert_irq_on_R8: assert property (@(posedge clk) disable iff (rst)
    (flags.irq_en && status != 2'b00) |=> irq);

  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (rst)
    !flags.irq_en |=> !irq);

  assert_uf_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    uf_p |=> status[0]);

  assert_early_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    early_p |=> status[1]);

  assert_freeze_R10: assert property (@(posedge clk) disable iff (rst)
    (frozen && !wr_en) |=> $stable(count));
endmodule

bind wdog_window_top wdog_window_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .idle_in(idle_in), .dbg_in(dbg_in),
  .wr_en(wr_en), .rst_req(rst_req), .rst_proc(rst_proc), .irq(irq),
  .count(cnt), .reload(reload), .flags(flags), .status(status),
  .uf_p(uf_p), .early_p(early_p)
);

// File: tb/wdog_window_top_test.sv
`timescale 1ns/1ps
module wdog_window_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0, idle_in = 1'b0, dbg_in = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rst_req, rst_proc, irq;

  int n_chk = 0, n_fail = 0;
  int pulses = 0, ppulses = 0, wide = 0;
  logic prev_req = 1'b0;

  always #10 clk = ~clk;

  wdog_window_top uut (
    .clk(clk), .rst(rst), .tick(tick), .idle_in(idle_in), .dbg_in(dbg_in),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rst_req(rst_req), .rst_proc(rst_proc), .irq(irq)
  );

  // pulse monitor on the reset request outputs
  always @(negedge clk) begin
    if (!rst) begin
      if (rst_req) pulses++;
      if (rst_proc) ppulses++;
      if (rst_req && prev_req) wide++;
    end
    prev_req = rst_req;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; idle_in = 1'b0; dbg_in = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    pulses = 0; ppulses = 0; wide = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic test_reset();
    logic [31:0] v;
    do_reset();
    check("R1 reset rst_req", 32'(rst_req), 0);
    check("R1 reset irq", 32'(irq), 0);
    rd(2'd1, v); check("R1 reset config", v, 32'h3FFF2FFF);
    rd(2'd2, v); check("R1 reset status", v, 0);
    rd(2'd3, v); check("R1 reset count", v, 32'hFFF);
  endtask

  task automatic test_write_once();
    logic [31:0] v;
    do_reset();
    wr(2'd1, 32'h0003_3008);
    rd(2'd1, v); check("R2 first write", v, 32'h0003_3008);
    rd(2'd3, v); check("R2 load on write", v, 8);
    wr(2'd1, 32'h0000_2010);
    rd(2'd1, v); check("R2 second write ignored", v, 32'h0003_3008);
    rd(2'd3, v); check("R2 counter untouched", v, 8);
  endtask

  task automatic test_underflow();
    logic [31:0] v;
    do_reset();
    wr(2'd1, 32'h0004_2004);
    ticks(2); rd(2'd3, v); check("R3 two steps", v, 2);
    ticks(2); check("R3 no fault at zero", pulses, 0);
    ticks(1);
    check("R3 R7 underflow pulse", pulses, 1);
    check("R7 pulse width", wide, 0);
    check("R7 no proc flag", ppulses, 0);
    check("R8 irq masked", 32'(irq), 0);
    rd(2'd3, v); check("R3 reloaded", v, 4);
    ticks(1); rd(2'd3, v); check("R3 keeps running", v, 3);
    rd(2'd2, v); check("R9 underflow bit", v, 1);
    rd(2'd2, v); check("R9 cleared by read", v, 0);
  endtask

  task automatic test_restart();
    logic [31:0] v;
    do_reset();
    wr(2'd1, 32'h0003_7008);
    ticks(2);
    wr(2'd0, 32'h5A00_0001);
    rd(2'd3, v); check("R4 wrong key ignored", v, 6);
    wr(2'd0, 32'hA500_0000);
    rd(2'd3, v); check("R4 no restart bit ignored", v, 6);
    ticks(3);
    wr(2'd0, 32'hA500_0001);
    repeat (3) @(negedge clk);
    rd(2'd3, v); check("R4 restart at delta", v, 8);
    check("R4 legal restart no fault", pulses, 0);
    wr(2'd0, 32'hA500_0001);
    repeat (3) @(negedge clk);
    check("R5 R7 early fault pulse", pulses, 1);
    check("R7 proc flag pulse", ppulses, 1);
    check("R8 irq raised", 32'(irq), 1);
    rd(2'd3, v); check("R5 reload after early", v, 8);
    rd(2'd2, v); check("R9 early bit", v, 2);
    repeat (2) @(negedge clk);
    check("R8 irq drops after clear", 32'(irq), 0);
  endtask

  task automatic test_no_reset_en();
    logic [31:0] v;
    do_reset();
    wr(2'd1, 32'h0002_1002);
    ticks(3);
    check("R7 no request without enable", pulses, 0);
    check("R8 irq on underflow", 32'(irq), 1);
    rd(2'd2, v); check("R9 status after underflow", v, 1);
  endtask

  task automatic test_disable();
    logic [31:0] v;
    do_reset();
    wr(2'd1, 32'h0000_A002);
    ticks(6);
    rd(2'd3, v); check("R6 count held", v, 2);
    check("R6 no underflow", pulses, 0);
    wr(2'd0, 32'hA500_0001);
    repeat (3) @(negedge clk);
    check("R6 restart no fault", pulses, 0);
    rd(2'd2, v); check("R6 status clear", v, 0);
  endtask

  task automatic test_halt();
    logic [31:0] v;
    do_reset();
    idle_in = 1'b1; ticks(5);
    rd(2'd3, v); check("R10 idle freeze", v, 32'hFFF);
    idle_in = 1'b0; dbg_in = 1'b1; ticks(3);
    rd(2'd3, v); check("R10 debug freeze", v, 32'hFFF);
    dbg_in = 1'b0; ticks(3);
    rd(2'd3, v); check("R10 runs when released", v, 32'hFFC);
    do_reset();
    wr(2'd1, 32'h0000_2010);
    idle_in = 1'b1; ticks(3);
    rd(2'd3, v); check("R10 idle without halt bit", v, 13);
    idle_in = 1'b0; dbg_in = 1'b1; ticks(2);
    rd(2'd3, v); check("R10 debug without halt bit", v, 11);
    dbg_in = 1'b0;
  endtask

  initial begin
    test_reset();
    test_write_once();
    test_underflow();
    test_restart();
    test_no_reset_en();
    test_disable();
    test_halt();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule